// File: doc/BRIEF.md
# Twisted-Pair Transmit Scrambler and Three-Level Line Encoder

This block is the transmit back end of a 100 Mb/s twisted-pair physical layer. It accepts 5-bit code groups from an upstream block-code encoder through a valid/ready handshake and shifts each group out one bit per clock, least significant bit first. Each serial bit is XORed with one bit of a key stream. An 11-stage shift register produces that key stream, and its feedback follows X[n] = X[n-11] XOR X[n-9].

The scrambled NRZ bit drives a three-level MLT-3 encoder. A zero keeps the line level where it is. A one moves the level one step around the ring zero, positive, zero, negative, zero. The level leaves the block as a 2-bit signed code. When no group is in flight, the key stream and the line level both hold. A receiver that keeps the same register in step and sees the same sequence of bit times can undo the scrambling.

Top module: `tx_mlt3_backend`

## Requirements
- R1: While reset is high and in the cycle after it is released, `line_lvl` is the zero code and `grp_ready` is high.
- R2: `grp_ready` is high only when no group is in flight or the bit on the line is the last bit of the current group. A group accepted at an edge drives `grp_ready` low in the next cycle.
- R3: A group is taken at a rising edge where `grp_valid` and `grp_ready` are both high. Its bits are sent over the next five cycles, one per clock, bit 0 first. With `grp_valid` held high the bit stream has no gaps.
- R4: The key-stream register resets to the seed 11'h5A5. Its state s[0] holds X[n-1] and s[10] holds X[n-11]. Each sent bit produces key = s[10] XOR s[8], shifts key into s[0], and sends data XOR key. The register never holds all zeros.
- R5: A scrambled 0 leaves `line_lvl` unchanged at the next edge.
- R6: A scrambled 1 moves `line_lvl` one step around the ring zero, positive, zero, negative. After reset the first step away from zero goes positive, and later excursions away from zero alternate in sign.
- R7: The line code is 2'b01 for positive, 2'b00 for zero and 2'b11 for negative. The code 2'b10 never appears.
- R8: In a cycle with no bit in flight, neither `line_lvl` nor the key stream changes.
- R9: A receiver model can rebuild the original bits. It reads a level change as 1 and no change as 0, XORs that with its own key stream started from the same seed, and advances that key stream only on sent bits.
- R10: A `grp_valid` that arrives while `grp_ready` is low has no effect. The data on `grp_data` in such cycles never reaches the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | 1 | A code group is offered |
| grp_data | input | 5 | Code group, bit 0 is sent first |
| grp_ready | output | 1 | The block takes a group at this edge if one is offered |
| line_lvl | output | 2 | Line level: 01 positive, 00 zero, 11 negative |

## Verification
The bench builds the block with its defaults: 5-bit groups, taps at stages 11 and 9, and seed 11'h5A5. At these values the reference model can hold the key stream as a plain history of past bits and index back 9 and 11 places. A second key history in the receiver model checks the output from the line side alone. Three stimulus patterns are used: back-to-back groups whose data changes while ready is low, groups with irregular gaps, and long runs of all-ones and all-zeros groups after a reset in mid-stream. Together they reach both signs of excursion, long level holds, idle stretches, and reloading the seed while bits are still in flight.

// File: rtl/tx3_pkg.sv
package tx3_pkg;

  typedef enum logic [1:0] {
    LV_ZERO = 2'b00,
    LV_POS  = 2'b01,
    LV_NEG  = 2'b11
  } lvl_e;

  // Level reached after one scrambled bit
  function automatic lvl_e mlt3_step(lvl_e cur, logic up_next, logic one);
    if (!one) return cur;
    if (cur == LV_ZERO) return up_next ? LV_POS : LV_NEG;
    return LV_ZERO;
  endfunction

  // Direction of the next excursion away from zero
  function automatic logic mlt3_dir(lvl_e cur, logic up_next, logic one);
    return (one && cur == LV_ZERO) ? ~up_next : up_next;
  endfunction

endpackage

// File: rtl/sym_serializer.sv
module sym_serializer #(
  parameter int SYM_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SYM_W-1:0] in_data,
  output logic             in_ready,
  output logic             bit_vld,
  output logic             bit_dat,
  output logic             grp_last
);
  localparam int IDX_W = (SYM_W > 1) ? $clog2(SYM_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SYM_W - 1);

  logic [SYM_W-1:0] sh_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;
  logic             take;

  assign grp_last = busy_q && (idx_q == LAST_IDX);
  assign in_ready = !busy_q || grp_last;
  assign take     = in_valid && in_ready;
  assign bit_vld  = busy_q;
  assign bit_dat  = sh_q[idx_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (take) begin
      sh_q   <= in_data;
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (grp_last) busy_q <= 1'b0;
      else          idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/keystream_scr.sv
module keystream_scr #(
  parameter int                TAP_HI = 11,
  parameter int                TAP_LO = 9,
  parameter logic [TAP_HI-1:0] SEED   = 11'h5A5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              din,
  output logic              key,
  output logic              dout,
  output logic [TAP_HI-1:0] state
);
  logic [TAP_HI-1:0] st_q;

  assign key   = st_q[TAP_HI-1] ^ st_q[TAP_LO-1];
  assign dout  = din ^ key;
  assign state = st_q;

  always_ff @(posedge clk) begin
    if (rst)      st_q <= SEED;
    else if (adv) st_q <= {st_q[TAP_HI-2:0], key};
  end
endmodule

// File: rtl/mlt3_enc.sv
module mlt3_enc
  import tx3_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  input  logic       one,
  output logic [1:0] lvl
);
  lvl_e lvl_q;
  logic up_q;

  assign lvl = lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= LV_ZERO;
      up_q  <= 1'b1;
    end else if (adv) begin
      lvl_q <= mlt3_step(lvl_q, up_q, one);
      up_q  <= mlt3_dir(lvl_q, up_q, one);
    end
  end
endmodule

// File: rtl/tx_mlt3_backend.sv
module tx_mlt3_backend #(
  parameter int                SYM_W  = 5,
  parameter int                TAP_HI = 11,
  parameter int                TAP_LO = 9,
  parameter logic [TAP_HI-1:0] SEED   = 11'h5A5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grp_valid,
  input  logic [SYM_W-1:0] grp_data,
  output logic             grp_ready,
  output logic [1:0]       line_lvl
);
  // Named internal events for the checker
  logic              bit_vld;
  logic              bit_dat;
  logic              grp_last;
  logic              key_bit;
  logic              scr_bit;
  logic [TAP_HI-1:0] ks_state;
  logic              ks_zero;

  sym_serializer #(.SYM_W(SYM_W)) u_ser (
    .clk(clk), .rst(rst),
    .in_valid(grp_valid), .in_data(grp_data), .in_ready(grp_ready),
    .bit_vld(bit_vld), .bit_dat(bit_dat), .grp_last(grp_last)
  );

  keystream_scr #(.TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .SEED(SEED)) u_scr (
    .clk(clk), .rst(rst),
    .adv(bit_vld), .din(bit_dat),
    .key(key_bit), .dout(scr_bit), .state(ks_state)
  );

  assign ks_zero = ~|ks_state;

  mlt3_enc u_mlt (
    .clk(clk), .rst(rst),
    .adv(bit_vld), .one(scr_bit),
    .lvl(line_lvl)
  );
endmodule

// File: rtl/tx_mlt3_chk.sv
module tx_mlt3_chk (
  input logic       clk,
  input logic       rst,
  input logic       grp_valid,
  input logic       grp_ready,
  input logic       bit_vld,
  input logic       scr_bit,
  input logic       ks_zero,
  input logic [1:0] lvl
);
  logic last_pos_q;

  always_ff @(posedge clk) begin
    if (rst)                last_pos_q <= 1'b0;
    else if (lvl == 2'b01)  last_pos_q <= 1'b1;
    else if (lvl == 2'b11)  last_pos_q <= 1'b0;
  end

  assert_legal_code_R7: assert property (@(posedge clk) disable iff (rst)
    lvl != 2'b10);

  assert_hold_on_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && !scr_bit) |=> $stable(lvl));

  assert_step_on_one_R6: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && scr_bit) |=> !$stable(lvl));

  assert_nonzero_returns_R6: assert property (@(posedge clk) disable iff (rst)
    (lvl != 2'b00 && bit_vld && scr_bit) |=> lvl == 2'b00);

  assert_alternate_sign_R6: assert property (@(posedge clk) disable iff (rst)
    (lvl == 2'b00 && bit_vld && scr_bit) |=> (lvl == (last_pos_q ? 2'b11 : 2'b01)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(lvl));

  assert_key_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    !ks_zero);

  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (rst)
    (grp_valid && grp_ready) |=> !grp_ready);
endmodule

bind tx_mlt3_backend tx_mlt3_chk u_chk (
  .clk(clk), .rst(rst),
  .grp_valid(grp_valid), .grp_ready(grp_ready),
  .bit_vld(bit_vld), .scr_bit(scr_bit),
  .ks_zero(ks_zero), .lvl(line_lvl)
);

// File: tb/sim_tx_mlt3_backend.sv
module sim_tx_mlt3_backend;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       grp_valid = 1'b0;
  logic [4:0] grp_data = '0;
  logic       grp_ready;
  logic [1:0] line_lvl;

  int errors = 0;
  int checks = 0;
  bit started = 0;

  always #2 clk = ~clk;

  tx_mlt3_backend u0 (
    .clk(clk), .rst(rst), .grp_valid(grp_valid), .grp_data(grp_data),
    .grp_ready(grp_ready), .line_lvl(line_lvl)
  );

  // ---- reference model ----
  bit pend[$];
  bit khist[$];
  bit dhist[$];
  int phase;
  bit sent;
  bit sent_bit;
  logic [1:0] prev_lvl;
  localparam logic [10:0] SEEDV = 11'h5A5;

  function automatic logic [1:0] enc(int p);
    case (p)
      1: return 2'b01;
      3: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic seed_hist(ref bit h[$]);
    h.delete();
    for (int k = 10; k >= 0; k--) h.push_back(SEEDV[k]);
  endtask

  function automatic bit next_key(ref bit h[$]);
    bit x;
    x = h[h.size() - 11] ^ h[h.size() - 9];
    h.push_back(x);
    void'(h.pop_front());
    return x;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      pend.delete();
      seed_hist(khist);
      phase = 0;
      sent = 0;
    end else begin
      bit rdy;
      rdy = pend.size() <= 1;
      sent = 0;
      if (pend.size() > 0) begin
        bit b;
        bit kb;
        b = pend.pop_front();
        kb = next_key(khist);
        if (b ^ kb) phase = (phase + 1) % 4;
        sent = 1;
        sent_bit = b;
      end
      if (grp_valid && rdy)
        for (int i = 0; i < 5; i++) pend.push_back(grp_data[i]);
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every cycle away from the clock edge
  always @(negedge clk) begin
    if (rst) begin
      seed_hist(dhist);
      prev_lvl = 2'b00;
    end else if (started) begin
      chk(line_lvl != 2'b10, "R7 legal code", line_lvl, 0);
      chk(line_lvl == enc(phase), "R4/R5/R6 level vs model (R3 R10 order)", line_lvl, enc(phase));
      chk(grp_ready == (pend.size() <= 1), "R2 ready", grp_ready, pend.size() <= 1);
      if (sent) begin
        bit r;
        bit rec;
        r = (line_lvl != prev_lvl);
        rec = r ^ next_key(dhist);
        chk(rec == sent_bit, "R9 descrambled bit", rec, sent_bit);
      end else begin
        chk(line_lvl == prev_lvl, "R8 idle hold", line_lvl, prev_lvl);
      end
      prev_lvl = line_lvl;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    started = 0;
    rst = 1;
    grp_valid = 0;
    repeat (2) @(negedge clk);
    chk(line_lvl == 2'b00, "R1 level in reset", line_lvl, 0);
    rst = 0;
    @(negedge clk);
    chk(line_lvl == 2'b00, "R1 level after reset", line_lvl, 0);
    chk(grp_ready == 1'b1, "R1 ready after reset", grp_ready, 1);
    started = 1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] rng = 16'hACE1;
    do_reset();
    // Back-to-back groups, data changing every cycle (R3, R10)
    for (int c = 0; c < 250; c++) begin
      grp_valid = 1;
      grp_data = 5'((c * 7 + 3) ^ (c >> 2));
      @(negedge clk);
    end
    // Irregular gaps (R8)
    for (int c = 0; c < 250; c++) begin
      rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
      grp_valid = rng[0] & rng[3];
      grp_data = rng[8:4];
      @(negedge clk);
    end
    // Reset in mid-stream, then long uniform runs (R1, R4, R6)
    grp_valid = 1;
    do_reset();
    for (int c = 0; c < 200; c++) begin
      grp_valid = 1;
      grp_data = ((c / 40) % 2 == 0) ? 5'b11111 : 5'b00000;
      @(negedge clk);
    end
    grp_valid = 0;
    repeat (30) @(negedge clk);
    finish_run();
  end
endmodule